// File: doc/BRIEF.md
# Multichannel Audio Serial Input Receiver

This block takes PCM audio from a three-wire serial link made of a bit clock, a frame clock and one data line. It turns each channel slot into a parallel word and presents it with a channel index and a one-cycle valid strobe. One frame carries one to six channels. The block can run in slave mode, where the far end drives both clocks into it. It can also run in master mode, where it generates both clocks from a programmable divider and receives its own clocks back through the same input path.

The incoming bit clock, frame clock and data are treated as asynchronous. Each passes through a two-flop synchronizer clocked by the system clock. A configuration bit selects which bit-clock edge samples the line. The frame is left-justified: the first bit of a frame is the one sampled at the bit-clock edge where the frame clock is first seen at its marker level. Each channel slot is 32 bit periods long and carries its word MSB first. The first 20 bits form the sample and the last 12 are discarded.

The receive state machine has three states. RX_HUNT waits after reset and is left only on a frame start. RX_DATA shifts in the 20 sample bits and moves to RX_PAD after the 20th. RX_PAD counts the 12 discarded bits; after the 32nd it emits the word and returns to RX_DATA for the next slot. A frame start moves any state to RX_DATA. The clock generator has two states. CG_HALT holds both clock outputs low and is left for CG_RUN when master mode is selected. CG_RUN toggles the clocks and returns to CG_HALT when master mode is deselected.

Top module: `audio_serial_rx`

## Requirements
- R1: In slave mode the 20-bit `sample_data` equals the first 20 line bits of a 32-bit channel slot, MSB first; bits 21 to 32 of the slot have no effect. The line is sampled on the rising bit-clock edge when `cfg_fall_edge`=0 and on the falling edge when it is 1.
- R2: A frame starts when the frame clock, sampled at sampling edges, changes into the level given by `cfg_marker_lvl`. The bit sampled at that same edge is the MSB of slot 0, and slot 0 is reported with `sample_chan`=0.
- R3: `sample_chan` rises by one for each completed slot and wraps to 0 after the effective channel count minus one. The effective count is `cfg_chan_count`, except that 0 counts as 1 and values above 6 count as 6.
- R4: A frame-clock change away from the marker level has no effect on slot alignment or channel numbering.
- R5: A frame start that arrives before the current slot has completed discards that partial slot; no `sample_valid` is issued for it.
- R6: `sample_valid` is high for exactly one system clock per completed slot. `sample_data` and `sample_chan` hold their values between pulses.
- R7: After reset no sample is issued until a frame start has been seen at a sampling edge following at least one earlier sampling edge.
- R8: In master mode `clk_drive_en` is 1 and `bclk_out` toggles every `cfg_half_div` system clocks, where values below 2 count as 2.
- R9: In master mode `lrclk_out` is at the marker level for the first 16 x (effective count) bit periods of each frame and at the opposite level for the rest. It changes only in the cycle in which `bclk_out` moves to the launch level, the level opposite to the sampling edge (equal to `cfg_fall_edge`).
- R10: In master mode the receiver samples `sdata_in` using its own generated clocks, and `bclk_in` and `lrclk_in` have no effect.
- R11: In slave mode `bclk_out`, `lrclk_out` and `clk_drive_en` stay low.
- R12: While reset is asserted, `sample_valid`, `sample_data`, `sample_chan`, `bclk_out` and `lrclk_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 selects master mode (block drives the clocks) |
| cfg_fall_edge | input | 1 | 1 samples data on the falling bit-clock edge |
| cfg_marker_lvl | input | 1 | Frame-clock level that marks the first half of a frame |
| cfg_chan_count | input | 3 | Channels per frame (0 counts as 1, above 6 counts as 6) |
| cfg_half_div | input | 8 | Master mode: system clocks per bit-clock half period |
| bclk_in | input | 1 | Slave mode bit clock |
| lrclk_in | input | 1 | Slave mode frame clock |
| sdata_in | input | 1 | Serial audio data |
| bclk_out | output | 1 | Master mode bit clock |
| lrclk_out | output | 1 | Master mode frame clock |
| clk_drive_en | output | 1 | Drive enable for the clock outputs |
| sample_data | output | 20 | Received sample |
| sample_chan | output | 3 | Channel index of the sample |
| sample_valid | output | 1 | One-cycle strobe for a new sample |

## Verification
If the receive state machine or its bit counter leaves the slot grid, the fault shows within one slot. The next word comes out shifted by some bit positions or with the wrong channel number, and it is not repaired until the next frame start. A stuck or misloaded channel counter shows as a wrong `sample_chan` on the first wrap, at most six slots later. A clock-generator fault shows at the clock pins within one half period as a wrong toggle interval. A wrong frame-clock width shows within one frame, and the received stream in master mode then loses its frame alignment as well.

// File: rtl/asrx_pkg.sv
package asrx_pkg;

    // receive framing state machine
    typedef enum logic [1:0] {
        RX_HUNT = 2'd0,
        RX_DATA = 2'd1,
        RX_PAD  = 2'd2
    } rx_state_e;

    // master clock generator state machine
    typedef enum logic {
        CG_HALT = 1'b0,
        CG_RUN  = 1'b1
    } cg_state_e;

    localparam int SYNC_STAGES = 2;

endpackage

// File: rtl/asrx_sync.sv
module asrx_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/asrx_clkgen.sv
module asrx_clkgen
    import asrx_pkg::*;
#(
    parameter int SLOT_BITS = 32,
    parameter int MAX_CH    = 6,
    parameter int CH_W      = 3,
    parameter int DIV_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] half_div,
    input  logic             launch_lvl,
    input  logic             marker_lvl,
    input  logic [CH_W-1:0]  nch,
    output logic             bclk_o,
    output logic             lrclk_o
);

    localparam int FB_W = $clog2(SLOT_BITS * MAX_CH + 1);

    cg_state_e        state, nxt;
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] half;
    logic [FB_W-1:0]  bpos, bpos_nx;
    logic [FB_W-1:0]  frame_len, half_len;
    logic             bclk_q, lr_q;
    logic             toggle, to_launch;

    always_comb begin
        half      = (half_div < DIV_W'(2)) ? DIV_W'(2) : half_div;
        frame_len = FB_W'(32'(nch) * SLOT_BITS);
        half_len  = FB_W'(32'(nch) * (SLOT_BITS / 2));
        toggle    = (div_cnt == half - DIV_W'(1));
        to_launch = ((~bclk_q) == launch_lvl);
        bpos_nx   = (bpos >= frame_len - FB_W'(1)) ? '0 : bpos + FB_W'(1);
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            CG_HALT: if (enable)  nxt = CG_RUN;
            CG_RUN:  if (!enable) nxt = CG_HALT;
            default: nxt = CG_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CG_HALT;
        else        state <= nxt;
    end

    // outputs and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            bpos    <= '0;
            bclk_q  <= 1'b0;
            lr_q    <= 1'b0;
        end else begin
            unique case (state)
                CG_HALT: begin
                    div_cnt <= '0;
                    bpos    <= frame_len - FB_W'(1);
                    bclk_q  <= 1'b0;
                    lr_q    <= 1'b0;
                end
                CG_RUN: begin
                    if (toggle) begin
                        div_cnt <= '0;
                        bclk_q  <= ~bclk_q;
                        if (to_launch) begin
                            bpos <= bpos_nx;
                            lr_q <= (bpos_nx < half_len) ? marker_lvl : ~marker_lvl;
                        end
                    end else begin
                        div_cnt <= div_cnt + DIV_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    assign bclk_o  = bclk_q;
    assign lrclk_o = lr_q;

endmodule

// File: rtl/asrx_deser.sv
module asrx_deser
    import asrx_pkg::*;
#(
    parameter int SLOT_BITS   = 32,
    parameter int SAMPLE_BITS = 20,
    parameter int CH_W        = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   samp_en,
    input  logic                   dat,
    input  logic                   lr,
    input  logic                   marker_lvl,
    input  logic [CH_W-1:0]        nch,
    output logic [SAMPLE_BITS-1:0] data_o,
    output logic [CH_W-1:0]        chan_o,
    output logic                   valid_o
);

    localparam int CNT_W = $clog2(SLOT_BITS);

    rx_state_e              state, nxt;
    logic [CNT_W-1:0]       bit_cnt;
    logic [SAMPLE_BITS-1:0] shreg;
    logic [CH_W-1:0]        ch_cur;
    logic                   lr_prev, seen;
    logic                   frame_start, last_data, last_slot;

    always_comb begin
        frame_start = samp_en && seen && (lr == marker_lvl) && (lr_prev != marker_lvl);
        last_data   = (bit_cnt == CNT_W'(SAMPLE_BITS - 1));
        last_slot   = (bit_cnt == CNT_W'(SLOT_BITS - 1));
    end

    // next state
    always_comb begin
        nxt = state;
        if (samp_en) begin
            if (frame_start) begin
                nxt = RX_DATA;
            end else begin
                unique case (state)
                    RX_HUNT: nxt = RX_HUNT;
                    RX_DATA: if (last_data) nxt = RX_PAD;
                    RX_PAD:  if (last_slot) nxt = RX_DATA;
                    default: nxt = RX_HUNT;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_HUNT;
        else        state <= nxt;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            ch_cur  <= '0;
            lr_prev <= 1'b0;
            seen    <= 1'b0;
            data_o  <= '0;
            chan_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (samp_en) begin
                lr_prev <= lr;
                seen    <= 1'b1;
                if (frame_start) begin
                    shreg   <= {shreg[SAMPLE_BITS-2:0], dat};
                    bit_cnt <= CNT_W'(1);
                    ch_cur  <= '0;
                end else begin
                    unique case (state)
                        RX_HUNT: ;
                        RX_DATA: begin
                            shreg   <= {shreg[SAMPLE_BITS-2:0], dat};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end
                        RX_PAD: begin
                            if (last_slot) begin
                                bit_cnt <= '0;
                                data_o  <= shreg;
                                chan_o  <= ch_cur;
                                valid_o <= 1'b1;
                                ch_cur  <= (ch_cur >= nch - CH_W'(1)) ? '0 : ch_cur + CH_W'(1);
                            end else begin
                                bit_cnt <= bit_cnt + CNT_W'(1);
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
    import asrx_pkg::*;
#(
    parameter int SLOT_BITS   = 32,
    parameter int SAMPLE_BITS = 20,
    parameter int MAX_CH      = 6,
    parameter int DIV_W       = 8,
    parameter int CH_W        = $clog2(MAX_CH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_master,
    input  logic                   cfg_fall_edge,
    input  logic                   cfg_marker_lvl,
    input  logic [CH_W-1:0]        cfg_chan_count,
    input  logic [DIV_W-1:0]       cfg_half_div,
    input  logic                   bclk_in,
    input  logic                   lrclk_in,
    input  logic                   sdata_in,
    output logic                   bclk_out,
    output logic                   lrclk_out,
    output logic                   clk_drive_en,
    output logic [SAMPLE_BITS-1:0] sample_data,
    output logic [CH_W-1:0]        sample_chan,
    output logic                   sample_valid
);

    logic [CH_W-1:0] nch_eff;
    logic [2:0]      raw_lines, sync_lines;
    logic            bclk_s, lr_s, dat_s;
    logic            bclk_d, samp_en;

    always_comb begin
        if (cfg_chan_count == '0)                nch_eff = CH_W'(1);
        else if (cfg_chan_count > CH_W'(MAX_CH)) nch_eff = CH_W'(MAX_CH);
        else                                     nch_eff = cfg_chan_count;
    end

    asrx_clkgen #(
        .SLOT_BITS (SLOT_BITS),
        .MAX_CH    (MAX_CH),
        .CH_W      (CH_W),
        .DIV_W     (DIV_W)
    ) u_clkgen (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cfg_master),
        .half_div   (cfg_half_div),
        .launch_lvl (cfg_fall_edge),
        .marker_lvl (cfg_marker_lvl),
        .nch        (nch_eff),
        .bclk_o     (bclk_out),
        .lrclk_o    (lrclk_out)
    );

    assign clk_drive_en = cfg_master;

    // master mode loops the generated clocks back through the same path
    assign raw_lines = cfg_master ? {bclk_out, lrclk_out, sdata_in}
                                  : {bclk_in,  lrclk_in,  sdata_in};

    asrx_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_lines),
        .q     (sync_lines)
    );

    assign {bclk_s, lr_s, dat_s} = sync_lines;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end

    assign samp_en = cfg_fall_edge ? (bclk_d & ~bclk_s) : (~bclk_d & bclk_s);

    asrx_deser #(
        .SLOT_BITS   (SLOT_BITS),
        .SAMPLE_BITS (SAMPLE_BITS),
        .CH_W        (CH_W)
    ) u_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_en    (samp_en),
        .dat        (dat_s),
        .lr         (lr_s),
        .marker_lvl (cfg_marker_lvl),
        .nch        (nch_eff),
        .data_o     (sample_data),
        .chan_o     (sample_chan),
        .valid_o    (sample_valid)
    );

endmodule

// File: rtl/asrx_chk.sv
module asrx_chk #(
    parameter int SAMPLE_BITS = 20,
    parameter int MAX_CH      = 6,
    parameter int CH_W        = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_master,
    input logic                   cfg_fall_edge,
    input logic [CH_W-1:0]        cfg_chan_count,
    input logic                   bclk_out,
    input logic                   lrclk_out,
    input logic [SAMPLE_BITS-1:0] sample_data,
    input logic [CH_W-1:0]        sample_chan,
    input logic                   sample_valid
);

    logic [CH_W-1:0] lim;
    always_comb begin
        if (cfg_chan_count == '0)                lim = CH_W'(1);
        else if (cfg_chan_count > CH_W'(MAX_CH)) lim = CH_W'(MAX_CH);
        else                                     lim = cfg_chan_count;
    end

    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> !sample_valid);

    p_hold_between_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> ($stable(sample_data) && $stable(sample_chan)));

    p_chan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> (sample_chan < lim));

    p_min_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !$stable(bclk_out)) |=> $stable(bclk_out));

    p_lr_on_launch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrclk_out) |-> (!$stable(bclk_out) && (bclk_out == cfg_fall_edge)));

    p_slave_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> (!bclk_out && !lrclk_out));

endmodule

bind audio_serial_rx asrx_chk #(
    .SAMPLE_BITS (SAMPLE_BITS),
    .MAX_CH      (MAX_CH),
    .CH_W        (CH_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_master     (cfg_master),
    .cfg_fall_edge  (cfg_fall_edge),
    .cfg_chan_count (cfg_chan_count),
    .bclk_out       (bclk_out),
    .lrclk_out      (lrclk_out),
    .sample_data    (sample_data),
    .sample_chan    (sample_chan),
    .sample_valid   (sample_valid)
);

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;

    localparam int H = 3;  // slave bit-clock half period in system clocks

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_master = 1'b0, cfg_fall_edge = 1'b0, cfg_marker_lvl = 1'b0;
    logic [2:0]  cfg_chan_count = 3'd2;
    logic [7:0]  cfg_half_div = 8'd3;
    logic        bclk_in = 1'b0, lrclk_in = 1'b0, sdata_in = 1'b0;
    logic        bclk_out, lrclk_out, clk_drive_en;
    logic [19:0] sample_data;
    logic [2:0]  sample_chan;
    logic        sample_valid;

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;
    logic cur_l = 1'b0;

    logic [19:0] got_d [64];
    logic [2:0]  got_c [64];
    int          got_n = 0;
    logic [19:0] exp_d [64];
    logic [2:0]  exp_c [64];
    int          exp_n = 0;

    always #2 clk = ~clk;

    audio_serial_rx u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fall_edge(cfg_fall_edge),
        .cfg_marker_lvl(cfg_marker_lvl), .cfg_chan_count(cfg_chan_count),
        .cfg_half_div(cfg_half_div), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .sdata_in(sdata_in), .bclk_out(bclk_out), .lrclk_out(lrclk_out),
        .clk_drive_en(clk_drive_en), .sample_data(sample_data),
        .sample_chan(sample_chan), .sample_valid(sample_valid)
    );

    always @(negedge clk) begin
        if (rst_n && sample_valid && got_n < 64) begin
            got_d[got_n] = sample_data;
            got_c[got_n] = sample_chan;
            got_n++;
        end
    end

    function automatic logic [19:0] mkval(int f, int s);
        return {f[7:0], s[3:0], 8'hC3};
    endfunction

    task automatic check(bit ok, string tag, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic do_reset(logic m, logic fe, logic pol, logic [2:0] cnt, logic [7:0] div);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_master = m; cfg_fall_edge = fe; cfg_marker_lvl = pol;
        cfg_chan_count = cnt; cfg_half_div = div;
        cur_l = fe;
        bclk_in = fe; lrclk_in = ~pol; sdata_in = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        got_n = 0;
        exp_n = 0;
    endtask

    task automatic tx_bit(logic lr, logic d);
        bclk_in = cur_l; lrclk_in = lr; sdata_in = d;
        repeat (H) @(negedge clk);
        bclk_in = ~cur_l;
        repeat (H) @(negedge clk);
    endtask

    task automatic tx_word(logic [19:0] v, logic lr);
        for (int b = 0; b < 32; b++) tx_bit(lr, (b < 20) ? v[19-b] : b[0]);
    endtask

    task automatic tx_frame(int nslots, int f, logic pol);
        for (int s = 0; s < nslots; s++) begin
            logic [19:0] v = mkval(f, s);
            for (int b = 0; b < 32; b++) begin
                int pos = s * 32 + b;
                logic lr = (pos < 16 * nslots) ? pol : ~pol;
                tx_bit(lr, (b < 20) ? v[19-b] : b[0]);
            end
        end
    endtask

    task automatic push(logic [19:0] d, logic [2:0] c);
        exp_d[exp_n] = d; exp_c[exp_n] = c; exp_n++;
    endtask

    task automatic compare(string tag);
        repeat (20) @(negedge clk);
        check(got_n == exp_n, {tag, " sample count"}, got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            check(got_d[i] == exp_d[i], {tag, " data"}, got_d[i], exp_d[i]);
            check(got_c[i] == exp_c[i], {tag, " chan"}, got_c[i], exp_c[i]);
        end
    endtask

    // R12: reset values
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!sample_valid, "R12 valid", sample_valid, 0);
        check(sample_data == 0, "R12 data", sample_data, 0);
        check(sample_chan == 0, "R12 chan", sample_chan, 0);
        check(!bclk_out && !lrclk_out, "R12 clocks", {bclk_out, lrclk_out}, 0);
    endtask

    // R7: no frame start after reset, no sample
    task automatic t_hunt();
        do_reset(0, 0, 1, 3'd2, 8'd3);
        for (int b = 0; b < 80; b++) tx_bit(1'b1, b[1]);
        compare("R7 hunt");
    endtask

    // R1 R2 R11: rising edge, low marker, stereo
    task automatic t_slave_stereo();
        do_reset(0, 0, 0, 3'd2, 8'd3);
        tx_bit(1'b1, 1'b0); tx_bit(1'b1, 1'b1);
        for (int f = 0; f < 3; f++) begin
            tx_frame(2, f, 1'b0);
            push(mkval(f, 0), 3'd0); push(mkval(f, 1), 3'd1);
        end
        compare("R1 R2 stereo");
        check(!bclk_out && !lrclk_out && !clk_drive_en, "R11 slave outputs",
              {bclk_out, lrclk_out, clk_drive_en}, 0);
    endtask

    // R1 R3: falling edge, high marker, count 7 clamps to 6
    task automatic t_slave_six();
        do_reset(0, 1, 1, 3'd7, 8'd3);
        tx_bit(1'b0, 1'b1); tx_bit(1'b0, 1'b0);
        for (int f = 0; f < 2; f++) begin
            tx_frame(6, f, 1'b1);
            for (int s = 0; s < 6; s++) push(mkval(f, s), 3'(s));
        end
        compare("R1 R3 six fall");
    endtask

    // R3: count 2 with four slots per frame wraps
    task automatic t_wrap();
        do_reset(0, 0, 1, 3'd2, 8'd3);
        tx_bit(1'b0, 1'b0);
        tx_frame(4, 5, 1'b1);
        for (int s = 0; s < 4; s++) push(mkval(5, s), 3'(s % 2));
        compare("R3 wrap");
    endtask

    // R3 R4: count 0 acts as 1; marker exits mid slot are ignored
    task automatic t_mono();
        do_reset(0, 0, 1, 3'd0, 8'd3);
        tx_bit(1'b0, 1'b0);
        for (int f = 0; f < 3; f++) begin
            tx_frame(1, f + 9, 1'b1);
            push(mkval(f + 9, 0), 3'd0);
        end
        compare("R3 R4 mono");
    endtask

    // R5: frame start inside slot 1 discards it
    task automatic t_abort();
        do_reset(0, 0, 1, 3'd4, 8'd3);
        tx_bit(1'b0, 1'b0);
        tx_word(20'hA1B2C, 1'b1);
        for (int b = 0; b < 12; b++) tx_bit(1'b0, 1'b1);
        tx_word(20'h3D4E5, 1'b1);
        tx_bit(1'b0, 1'b0);
        push(20'hA1B2C, 3'd0); push(20'h3D4E5, 3'd0);
        compare("R5 abort");
    endtask

    // R8 R9 R10: master mode with bench acting as transmitter
    task automatic t_master(logic fe, logic pol, logic [2:0] cnt, logic [7:0] div, int exp_half);
        logic pb, pl, tprev;
        int since_b = 0, toggles = 0, bad_half = 0, bad_lr = 0, bad_len = 0;
        int lr_changes = 0, launches = 0, frame = -1, pos = 0, k0;
        do_reset(1, fe, pol, cnt, div);
        pb = bclk_out; pl = lrclk_out; tprev = lrclk_out;
        check(clk_drive_en == 1'b1, "R8 drive enable", clk_drive_en, 1);
        repeat (2400) begin
            @(negedge clk);
            since_b++;
            bclk_in = $urandom_range(0, 1); lrclk_in = $urandom_range(0, 1);
            if (bclk_out != pb) begin
                toggles++;
                if (toggles > 1 && since_b != exp_half) bad_half++;
                since_b = 0;
            end
            if (lrclk_out != pl && !(bclk_out != pb && bclk_out == fe)) bad_lr++;
            if (bclk_out != pb && bclk_out == fe) begin
                if (lrclk_out != pl) begin
                    if (lr_changes >= 1 && launches != 16 * int'(cnt)) bad_len++;
                    lr_changes++;
                    launches = 1;
                end else begin
                    launches++;
                end
                if (lrclk_out == pol && tprev != pol) begin frame++; pos = 0; end
                else pos++;
                tprev = lrclk_out;
                if (frame >= 0) begin
                    logic [19:0] v = mkval(frame, pos / 32);
                    sdata_in = ((pos % 32) < 20) ? v[19 - (pos % 32)] : 1'b1;
                end
            end
            pb = bclk_out; pl = lrclk_out;
        end
        check(bad_half == 0, "R8 half period", bad_half, 0);
        check(bad_lr == 0, "R9 change at launch", bad_lr, 0);
        check(bad_len == 0 && lr_changes >= 3, "R9 marker width", bad_len, 0);
        check(got_n >= 4, "R10 samples received", got_n, 4);
        k0 = (got_n > 0) ? int'(got_d[0][19:12]) : 0;
        check(k0 <= 1, "R10 first frame", k0, 1);
        for (int i = 0; i < got_n; i++) begin
            int c = i % int'(cnt);
            logic [19:0] e = mkval(k0 + i / int'(cnt), c);
            check(got_d[i] == e, "R10 master data", got_d[i], e);
            check(got_c[i] == 3'(c), "R10 master chan", got_c[i], c);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finished = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hunt();
        t_slave_stereo();
        t_slave_six();
        t_wrap();
        t_mono();
        t_abort();
        t_master(1'b0, 1'b1, 3'd2, 8'd3, 3);
        t_master(1'b1, 1'b0, 3'd3, 8'd0, 2);
        if (!finished) begin
            finished = 1'b1;
            summary();
            $finish;
        end
    end

endmodule